// File: doc/BRIEF.md
# Guard Tail-Pointer Swap Unit

This unit keeps a small table of guards. A guard is a register that holds the 64-bit pointer to the last element of an ordered request stream. Several requester ports issue two kinds of command. A create command takes a free guard and returns its number. A swap command writes the requester's new element pointer into a guard and returns the pointer that was there before. The requester then links that old tail to its new element. That linking, element storage and the routing of responses back to requesters are handled outside this unit.

A round-robin arbiter grants one command per cycle. Commands from independent ports are therefore merged into one total order. Every grant receives a sequence number, and that number defines the position of the command in the stream. Guard state is held only here, so no requester ever works on a stale copy of a tail.

A port raises its request and keeps it high until it sees its grant. The grant comes in the same cycle as the request when the port wins arbitration. The response is registered and shows up one cycle after the grant. Back-to-back swaps to the same guard chain correctly: each swap returns the pointer that the swap before it installed.

Top module: `guard_swap_unit`

## Requirements
- R1: While reset is asserted and after it is released, no guard is allocated, `rsp_valid` is 0 and the next granted command receives sequence number 0.
- R2: In any cycle at most one bit of `grant` is set, and only for a port whose `req_valid` is high. A winning request is granted combinationally in the cycle it is presented.
- R3: Arbitration is round-robin. After port p is granted, priority starts at port p+1 and wraps around to port 0. After reset, priority starts at port 0.
- R4: A create (`req_op` = 1) allocates the lowest-numbered free guard and sets that guard's tail to null (zero). The response gives the guard number in `rsp_guard`, 0 in `rsp_old_tail` and 0 in `rsp_err`.
- R5: A swap (`req_op` = 0) on an allocated guard returns the guard's previous tail in `rsp_old_tail` and installs `req_ptr` as the new tail.
- R6: A swap on an unallocated guard, or a create when no guard is free, sets `rsp_err` = 1 and returns `rsp_old_tail` = 0. It changes no guard and allocates nothing.
- R7: Each granted command carries `rsp_seq`, which is one more than the value carried by the previous granted command and wraps at its width.
- R8: The response for a grant appears with `rsp_valid` = 1 exactly one clock edge after the grant. A swap granted in the next cycle already sees the tail written by the previous swap.
- R9: `rsp_port` gives the index of the granted port, and `rsp_op` echoes that port's command (1 = create, 0 = swap).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORT | Request pending, one bit per port |
| req_op | input | NPORT | Command per port: 1 = create, 0 = swap |
| req_guard | input | NPORT*GID_W | Guard number per port (used by swap) |
| req_ptr | input | NPORT*PTR_W | New tail pointer per port (used by swap) |
| grant | output | NPORT | One-hot grant, same cycle as the request |
| rsp_valid | output | 1 | Response present |
| rsp_port | output | PIDX_W | Port the response belongs to |
| rsp_op | output | 1 | Command that was served |
| rsp_err | output | 1 | Unallocated guard, or no free guard |
| rsp_guard | output | GID_W | Guard that was swapped or allocated |
| rsp_old_tail | output | PTR_W | Previous tail, or zero |
| rsp_seq | output | SEQ_W | Position of the command in the total order |

## Verification
A grant is combinational, so the bench drives requests on the falling edge and reads `grant` a little later in the same low phase. The response is due at the next rising edge, so the bench checks every response field on the falling edge that follows that rising edge. For back-to-back swaps, the bench drops each winner's request on that same falling edge. It then checks, at once, that the next grant goes to the next port in rotation. It also checks that each returned tail is the pointer the previous winner supplied.

// File: rtl/gsu_pkg.sv
package gsu_pkg;
  typedef enum logic {
    OP_SWAP   = 1'b0,
    OP_CREATE = 1'b1
  } gsu_op_e;
endpackage

// File: rtl/gsu_rr_arb.sv
module gsu_rr_arb #(
  parameter int NPORT  = 4,
  localparam int PIDX_W = $clog2(NPORT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORT-1:0]  req,
  output logic [NPORT-1:0]  gnt,
  output logic [PIDX_W-1:0] gnt_idx,
  output logic              gnt_any
);
  logic [PIDX_W-1:0] prio_q, prio_d;

  // Scan starting at the priority pointer; first requester wins.
  always_comb begin
    int idx;
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 0; k < NPORT; k++) begin
      idx = int'(prio_q) + k;
      if (idx >= NPORT) idx = idx - NPORT;
      if (!gnt_any && req[idx]) begin
        gnt_any      = 1'b1;
        gnt_idx      = PIDX_W'(idx);
        gnt[idx]     = 1'b1;
      end
    end
  end

  always_comb begin
    prio_d = prio_q;
    if (gnt_any) begin
      if (gnt_idx == PIDX_W'(NPORT - 1)) prio_d = '0;
      else                              prio_d = gnt_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prio_q <= '0;
    else if (gnt_any) prio_q <= prio_d;
  end
endmodule

// File: rtl/gsu_guard_table.sv
module gsu_guard_table #(
  parameter int NGUARD = 8,
  parameter int PTR_W  = 64,
  localparam int GID_W = $clog2(NGUARD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_create,
  input  logic             do_swap,
  input  logic [GID_W-1:0] rd_gid,
  input  logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_tail,
  output logic             rd_alloc,
  output logic             free_found,
  output logic [GID_W-1:0] free_gid
);
  logic [NGUARD-1:0] alloc_q, alloc_d;
  logic [PTR_W-1:0]  tail_q [NGUARD];

  assign rd_tail  = tail_q[rd_gid];
  assign rd_alloc = alloc_q[rd_gid];

  // Lowest-numbered free guard.
  always_comb begin
    free_found = 1'b0;
    free_gid   = '0;
    for (int g = 0; g < NGUARD; g++) begin
      if (!free_found && !alloc_q[g]) begin
        free_found = 1'b1;
        free_gid   = GID_W'(g);
      end
    end
  end

  always_comb begin
    alloc_d = alloc_q;
    if (do_create) alloc_d[free_gid] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         alloc_q <= '0;
    else if (do_create) alloc_q <= alloc_d;
  end

  for (genvar g = 0; g < NGUARD; g++) begin : g_tail
    logic wen;
    logic [PTR_W-1:0] tail_d;
    assign wen    = (do_create && free_gid == GID_W'(g)) ||
                    (do_swap && rd_gid == GID_W'(g));
    assign tail_d = do_create ? '0 : wr_ptr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tail_q[g] <= '0;
      else if (wen) tail_q[g] <= tail_d;
    end
  end
endmodule

// File: rtl/guard_swap_unit.sv
module guard_swap_unit
  import gsu_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int NGUARD = 8,
  parameter int PTR_W  = 64,
  parameter int SEQ_W  = 16,
  localparam int PIDX_W = $clog2(NPORT),
  localparam int GID_W  = $clog2(NGUARD)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        req_valid,
  input  logic [NPORT-1:0]        req_op,
  input  logic [NPORT*GID_W-1:0]  req_guard,
  input  logic [NPORT*PTR_W-1:0]  req_ptr,
  output logic [NPORT-1:0]        grant,
  output logic                    rsp_valid,
  output logic [PIDX_W-1:0]       rsp_port,
  output logic                    rsp_op,
  output logic                    rsp_err,
  output logic [GID_W-1:0]        rsp_guard,
  output logic [PTR_W-1:0]        rsp_old_tail,
  output logic [SEQ_W-1:0]        rsp_seq
);
  logic [PIDX_W-1:0] gnt_idx;
  logic              gnt_any;
  gsu_op_e           sel_op;
  logic [GID_W-1:0]  sel_gid;
  logic [PTR_W-1:0]  sel_ptr;
  logic [PTR_W-1:0]  rd_tail;
  logic              rd_alloc, free_found;
  logic [GID_W-1:0]  free_gid;
  logic              is_create, create_ok, swap_ok;
  logic [SEQ_W-1:0]  seq_q;

  gsu_rr_arb #(.NPORT(NPORT)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid),
    .gnt(grant), .gnt_idx(gnt_idx), .gnt_any(gnt_any)
  );

  assign sel_op  = gsu_op_e'(req_op[gnt_idx]);
  assign sel_gid = req_guard[gnt_idx*GID_W +: GID_W];
  assign sel_ptr = req_ptr[gnt_idx*PTR_W +: PTR_W];

  assign is_create = gnt_any && (sel_op == OP_CREATE);
  assign create_ok = is_create && free_found;
  assign swap_ok   = gnt_any && (sel_op == OP_SWAP) && rd_alloc;

  gsu_guard_table #(.NGUARD(NGUARD), .PTR_W(PTR_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .do_create(create_ok), .do_swap(swap_ok),
    .rd_gid(sel_gid), .wr_ptr(sel_ptr),
    .rd_tail(rd_tail), .rd_alloc(rd_alloc),
    .free_found(free_found), .free_gid(free_gid)
  );

  // Response next-state
  logic              v_d, op_d, err_d;
  logic [PIDX_W-1:0] port_d;
  logic [GID_W-1:0]  gid_d;
  logic [PTR_W-1:0]  tail_d;
  always_comb begin
    v_d    = gnt_any;
    port_d = gnt_idx;
    op_d   = (sel_op == OP_CREATE);
    err_d  = gnt_any && !(create_ok || swap_ok);
    gid_d  = is_create ? free_gid : sel_gid;
    tail_d = swap_ok ? rd_tail : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_port     <= '0;
      rsp_op       <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_guard    <= '0;
      rsp_old_tail <= '0;
      rsp_seq      <= '0;
    end else if (gnt_any) begin
      rsp_port     <= port_d;
      rsp_op       <= op_d;
      rsp_err      <= err_d;
      rsp_guard    <= gid_d;
      rsp_old_tail <= tail_d;
      rsp_seq      <= seq_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seq_q <= '0;
    else if (gnt_any) seq_q <= seq_q + 1'b1;
  end
endmodule

// File: rtl/gsu_checker.sv
module gsu_checker #(
  parameter int NPORT  = 4,
  parameter int PTR_W  = 64,
  parameter int SEQ_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] req_valid,
  input logic [NPORT-1:0] grant,
  input logic             rsp_valid,
  input logic             rsp_op,
  input logic             rsp_err,
  input logic [PTR_W-1:0] rsp_old_tail,
  input logic [SEQ_W-1:0] rsp_seq
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2
  AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_valid) == '0); // R2
  AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> rsp_valid); // R8
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|grant) |=> !rsp_valid); // R8
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid || rsp_seq == SEQ_W'($past(rsp_seq) + 1'b1))); // R7
  AST_CREATE_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_op && !rsp_err) |-> rsp_old_tail == '0); // R4
  AST_ERR_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_old_tail == '0); // R6
endmodule

bind guard_swap_unit gsu_checker #(.NPORT(NPORT), .PTR_W(PTR_W), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .grant(grant),
  .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_err(rsp_err),
  .rsp_old_tail(rsp_old_tail), .rsp_seq(rsp_seq)
);

// File: tb/guard_swap_unit_bench.sv
module guard_swap_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPORT = 4, NGUARD = 8, PTR_W = 64, SEQ_W = 16;
  localparam int GID_W = 3, PIDX_W = 2;
  localparam int NVEC = 12;

  // Vector table: port, op (1=create), guard, ptr, expected err/guard/old tail
  localparam int          T_PORT [NVEC] = '{0,1,2,3,0,1,2,3,0,1,2,3};
  localparam bit          T_OP   [NVEC] = '{0,1,0,0,1,0,0,0,1,0,0,0};
  localparam int          T_GID  [NVEC] = '{3,0,0,0,0,1,2,0,0,2,1,1};
  localparam logic [63:0] T_PTR  [NVEC] = '{64'hAA, 64'h0, 64'h1111, 64'h2222, 64'h0,
    64'hDEAD_BEEF_0000_0001, 64'h55, 64'h3333, 64'h0, 64'h77, 64'h0, 64'h9};
  localparam bit          E_ERR  [NVEC] = '{1,0,0,0,0,0,1,0,0,0,0,0};
  localparam int          E_GID  [NVEC] = '{3,0,0,0,1,1,2,0,2,2,1,1};
  localparam logic [63:0] E_TAIL [NVEC] = '{64'h0, 64'h0, 64'h0, 64'h1111, 64'h0, 64'h0,
    64'h0, 64'h2222, 64'h0, 64'h0, 64'hDEAD_BEEF_0000_0001, 64'h0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPORT-1:0]       req_valid = '0;
  logic [NPORT-1:0]       req_op = '0;
  logic [NPORT*GID_W-1:0] req_guard = '0;
  logic [NPORT*PTR_W-1:0] req_ptr = '0;
  logic [NPORT-1:0]       grant;
  logic                   rsp_valid, rsp_op, rsp_err;
  logic [PIDX_W-1:0]      rsp_port;
  logic [GID_W-1:0]       rsp_guard;
  logic [PTR_W-1:0]       rsp_old_tail;
  logic [SEQ_W-1:0]       rsp_seq;

  int checks = 0, errors = 0, exp_seq = 0, last_port = -1, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  guard_swap_unit #(.NPORT(NPORT), .NGUARD(NGUARD), .PTR_W(PTR_W), .SEQ_W(SEQ_W)) u_guard_swap_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_guard(req_guard), .req_ptr(req_ptr), .grant(grant),
    .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_op(rsp_op), .rsp_err(rsp_err),
    .rsp_guard(rsp_guard), .rsp_old_tail(rsp_old_tail), .rsp_seq(rsp_seq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // One command from one port; checks grant at once, response one edge later.
  task automatic issue(input int p, input bit op, input int gid, input logic [63:0] ptr,
                       input bit e_err, input int e_gid, input logic [63:0] e_tail);
    @(negedge clk);
    req_valid[p] = 1'b1;
    req_op[p]    = op;
    req_guard[p*GID_W +: GID_W] = GID_W'(gid);
    req_ptr[p*PTR_W +: PTR_W]   = ptr;
    #1;
    chk(grant == NPORT'(1 << p), "R2 grant", 64'(grant), 64'(1 << p));
    @(negedge clk);
    req_valid[p] = 1'b0;
    chk(rsp_valid == 1'b1, "R8 rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_port == PIDX_W'(p) && rsp_op == op, "R9 port/op", {rsp_port, rsp_op}, {p[1:0], op});
    chk(rsp_err == e_err, op ? "R4 err" : "R6 err", 64'(rsp_err), 64'(e_err));
    chk(rsp_guard == GID_W'(e_gid), "R4 guard", 64'(rsp_guard), 64'(e_gid));
    chk(rsp_old_tail == e_tail, "R5 old tail", rsp_old_tail, e_tail);
    chk(rsp_seq == SEQ_W'(exp_seq), "R7 seq", 64'(rsp_seq), 64'(exp_seq));
    exp_seq++;
    last_port = p;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    // R1: reset state
    #3;
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && grant == '0, "R1 idle after reset", 64'(rsp_valid), 64'd0);

    // Vector table
    for (int i = 0; i < NVEC; i++)
      issue(T_PORT[i], T_OP[i], T_GID[i], T_PTR[i], E_ERR[i], E_GID[i], E_TAIL[i]);

    // R4/R6: fill remaining guards 3..7, then a create must fail
    for (int g = 3; g < NGUARD; g++) issue(g % NPORT, 1'b1, 0, 64'h0, 1'b0, g, 64'h0);
    issue(1, 1'b1, 0, 64'h0, 1'b1, 0, 64'h0);
    // R6: failed create left guard 7 untouched
    issue(2, 1'b0, 7, 64'hABC, 1'b0, 7, 64'h0);

    // R3/R8: all ports swap guard 0 at once, back to back
    begin
      logic [63:0] prev;
      int start;
      prev  = 64'h3333;
      start = (last_port + 1) % NPORT;
      @(negedge clk);
      for (int p = 0; p < NPORT; p++) begin
        req_valid[p] = 1'b1;
        req_op[p]    = 1'b0;
        req_guard[p*GID_W +: GID_W] = '0;
        req_ptr[p*PTR_W +: PTR_W]   = 64'h100 + 64'(p);
      end
      for (int i = 0; i < NPORT; i++) begin
        int ep;
        ep = (start + i) % NPORT;
        #1;
        chk(grant == NPORT'(1 << ep), "R3 rotation", 64'(grant), 64'(1 << ep));
        @(negedge clk);
        req_valid[ep] = 1'b0;
        chk(rsp_port == PIDX_W'(ep), "R3 rsp_port", 64'(rsp_port), 64'(ep));
        chk(rsp_old_tail == prev, "R8 chained tail", rsp_old_tail, prev);
        chk(rsp_seq == SEQ_W'(exp_seq), "R7 seq burst", 64'(rsp_seq), 64'(exp_seq));
        exp_seq++;
        prev = 64'h100 + 64'(ep);
      end
    end

    // R1: reset mid-run clears guards and sequence
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(rsp_valid == 1'b0, "R1 async clear", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_seq = 0;
    issue(3, 1'b0, 1, 64'h5, 1'b1, 1, 64'h0);   // R1/R6: guard 1 no longer allocated
    issue(2, 1'b1, 0, 64'h0, 1'b0, 0, 64'h0);   // R1/R4: first create gets guard 0
    issue(0, 1'b0, 0, 64'h42, 1'b0, 0, 64'h0);  // R4: new guard starts null

    finish_run();
  end
endmodule